// File: doc/BRIEF.md
# Telecontrol Link Frame Checker

This block sits behind a serial character receiver on a telecontrol link. Each byte it receives carries a flag that tells whether the character arrived with a framing or parity fault. The block looks for the start of a frame and follows one of three shapes. A long frame carries a repeated length octet and a repeated opening symbol. A short frame carries one control octet and one address octet. A lone acknowledge symbol is a complete message on its own. The block checks each frame's structure and its modulo-256 checksum.

Control, address and user octets are held in an internal store until the closing symbol has been verified. Only then are they streamed to the user over a valid/ready/last handshake, and a good pulse follows the final beat. A frame that fails any check is dropped as a whole. An error pulse tells the character layer to enforce its idle recovery, and the checker goes back to hunting for a start symbol.

Top module: `link_frame_checker`

## Requirements
- R1: A long frame `68h, L, L, 68h, U1..UL, S, 16h` with 1 <= L <= 255 and S equal to the sum modulo 256 of U1..UL streams exactly L beats U1..UL in order. `out_last` is high only on beat L, and `frame_good` pulses for one cycle in the cycle after the final handshake.
- R2: A short frame `10h, C, A, S, 16h` with S = (C + A) mod 256 streams two beats, C then A, with `out_last` on A, followed by a `frame_good` pulse.
- R3: A byte E5h received while hunting with no character fault raises `ack_good` for one cycle in the cycle after that byte, and streams nothing.
- R4: A checksum octet that differs from the modulo-256 sum (of U1..UL, or of C and A) rejects the frame. `frame_err` pulses in the cycle after the checksum byte and no beat is released.
- R5: In a long frame, two length octets that differ, or a length of zero, reject the frame with a `frame_err` pulse.
- R6: In a long frame, a fourth octet other than 68h rejects the frame with a `frame_err` pulse.
- R7: A closing octet other than 16h rejects the frame, with `frame_err` in the cycle after that octet.
- R8: A byte flagged with `in_char_err` at any position of a frame, including its closing octet, rejects the frame with `frame_err` and releases nothing. The fault takes precedence over an otherwise correct closing octet.
- R9: While hunting, fault-free bytes other than 68h, 10h and E5h are ignored and produce no pulse and no beat.
- R10: No beat is offered before the closing octet is verified. While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold their values.
- R11: Bytes that arrive while a frame is being streamed out are discarded and start nothing.
- R12: After reset, `out_valid`, `frame_good`, `frame_err` and `ack_good` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received character is present this cycle |
| in_byte | input | 8 | Received character |
| in_char_err | input | 1 | Character arrived with a start, stop or parity fault |
| out_valid | output | 1 | A released octet is offered |
| out_byte | output | 8 | Released octet (control, address, user data) |
| out_last | output | 1 | Offered octet is the final one of the frame |
| out_ready | input | 1 | User accepts the offered octet |
| frame_good | output | 1 | One-cycle pulse after a frame has been fully released |
| frame_err | output | 1 | One-cycle pulse on rejection, toward the character layer |
| ack_good | output | 1 | One-cycle pulse on a lone acknowledge symbol |

## Verification
Two functions can meet in one cycle: the closing-octet check and the character-fault check. The bench provokes this by sending a correct 16h closing octet with `in_char_err` set. It then expects one `frame_err` pulse, no `frame_good` and no beat, so the fault wins. A second overlap is arrival of new bytes during the output drain. The bench pushes acknowledge symbols straight after a closing octet while `out_ready` stalls. It expects the drained beats to match the frame and `ack_good` never to rise.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  localparam logic [7:0] SYM_LONG  = 8'h68;
  localparam logic [7:0] SYM_SHORT = 8'h10;
  localparam logic [7:0] SYM_ACK   = 8'hE5;
  localparam logic [7:0] SYM_STOP  = 8'h16;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_LEN_A,
    ST_LEN_B,
    ST_REOPEN,
    ST_USER,
    ST_VSUM,
    ST_VSTOP,
    ST_CTRL,
    ST_ADDR,
    ST_FSUM,
    ST_FSTOP
  } prs_state_t;

  // running checksum: plain 8-bit add, carry dropped
  function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

endpackage

// File: rtl/lfc_parser.sv
module lfc_parser
  import lfc_pkg::*;
#(
  parameter int MAX_USER = 255,
  parameter int LEN_W    = 8,
  localparam int AW      = $clog2(MAX_USER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_char_err,
  input  logic             hold,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             commit,
  output logic [LEN_W-1:0] commit_len,
  output logic             reject_q,
  output logic             ack_q
);

  prs_state_t       st, st_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [7:0]       acc_q, acc_n;
  logic             take;
  logic             rej_now;
  logic             ack_now;

  assign take = in_valid && !hold;

  always_comb begin
    st_n       = st;
    len_n      = len_q;
    cnt_n      = cnt_q;
    acc_n      = acc_q;
    wr_en      = 1'b0;
    wr_addr    = '0;
    wr_data    = in_byte;
    commit     = 1'b0;
    commit_len = len_q;
    rej_now    = 1'b0;
    ack_now    = 1'b0;
    if (take) begin
      if (in_char_err) begin
        rej_now = 1'b1;
        st_n    = ST_HUNT;
      end else begin
        unique case (st)
          ST_HUNT: begin
            if (in_byte == SYM_LONG)       st_n = ST_LEN_A;
            else if (in_byte == SYM_SHORT) st_n = ST_CTRL;
            else if (in_byte == SYM_ACK)   ack_now = 1'b1;
          end
          ST_LEN_A: begin
            len_n = LEN_W'(in_byte);
            st_n  = ST_LEN_B;
          end
          ST_LEN_B: begin
            if (LEN_W'(in_byte) != len_q || in_byte == 8'd0 ||
                int'(in_byte) > MAX_USER) begin
              rej_now = 1'b1;
              st_n    = ST_HUNT;
            end else begin
              st_n = ST_REOPEN;
            end
          end
          ST_REOPEN: begin
            if (in_byte == SYM_LONG) begin
              st_n  = ST_USER;
              cnt_n = '0;
              acc_n = 8'd0;
            end else begin
              rej_now = 1'b1;
              st_n    = ST_HUNT;
            end
          end
          ST_USER: begin
            wr_en   = 1'b1;
            wr_addr = cnt_q[AW-1:0];
            acc_n   = sum8(acc_q, in_byte);
            cnt_n   = cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) st_n = ST_VSUM;
          end
          ST_VSUM: begin
            if (in_byte == acc_q) st_n = ST_VSTOP;
            else begin
              rej_now = 1'b1;
              st_n    = ST_HUNT;
            end
          end
          ST_VSTOP: begin
            st_n = ST_HUNT;
            if (in_byte == SYM_STOP) commit = 1'b1;
            else                     rej_now = 1'b1;
          end
          ST_CTRL: begin
            wr_en   = 1'b1;
            wr_addr = AW'(0);
            acc_n   = sum8(8'd0, in_byte);
            st_n    = ST_ADDR;
          end
          ST_ADDR: begin
            wr_en   = 1'b1;
            wr_addr = AW'(1);
            acc_n   = sum8(acc_q, in_byte);
            st_n    = ST_FSUM;
          end
          ST_FSUM: begin
            if (in_byte == acc_q) st_n = ST_FSTOP;
            else begin
              rej_now = 1'b1;
              st_n    = ST_HUNT;
            end
          end
          ST_FSTOP: begin
            st_n       = ST_HUNT;
            commit_len = LEN_W'(2);
            if (in_byte == SYM_STOP) commit = 1'b1;
            else                     rej_now = 1'b1;
          end
          default: st_n = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      len_q    <= '0;
      cnt_q    <= '0;
      acc_q    <= 8'd0;
      reject_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      st       <= st_n;
      len_q    <= len_n;
      cnt_q    <= cnt_n;
      acc_q    <= acc_n;
      reject_q <= rej_now;
      ack_q    <= ack_now;
    end
  end

  // a rejection always leaves the parser hunting
  p_reject_to_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> st == ST_HUNT);

  // a user phase is only entered with a checked, non-zero length
  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REOPEN || st == ST_USER) |-> len_q != '0);

  p_user_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_USER |-> cnt_q < len_q);

  p_ack_from_hunt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(st) == ST_HUNT);

  p_no_take_while_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> st == $past(st));

endmodule

// File: rtl/lfc_store.sv
module lfc_store #(
  parameter int DEPTH = 255,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'd0;

  p_wr_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < DEPTH);

endmodule

// File: rtl/lfc_drain.sv
module lfc_drain #(
  parameter int MAX_USER = 255,
  parameter int LEN_W    = 8,
  localparam int AW      = $clog2(MAX_USER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             frame_good,
  output logic             busy
);

  logic             active;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] len;
  logic             at_end;
  logic             beat;

  assign at_end    = (idx == len - 1'b1);
  assign beat      = active && out_ready;
  assign rd_addr   = idx[AW-1:0];
  assign out_valid = active;
  assign out_byte  = rd_data;
  assign out_last  = active && at_end;
  assign busy      = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      len        <= '0;
      frame_good <= 1'b0;
    end else begin
      frame_good <= 1'b0;
      if (commit && !active) begin
        active <= 1'b1;
        idx    <= '0;
        len    <= commit_len;
      end else if (beat) begin
        if (at_end) begin
          active     <= 1'b0;
          frame_good <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  p_good_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> $past(out_valid && out_ready && out_last));

  p_no_commit_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !commit);

endmodule

// File: rtl/link_frame_checker.sv
module link_frame_checker #(
  parameter int MAX_USER = 255,
  parameter int LEN_W    = 8,
  localparam int AW      = $clog2(MAX_USER)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_char_err,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_last,
  input  logic       out_ready,
  output logic       frame_good,
  output logic       frame_err,
  output logic       ack_good
);

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic             commit;
  logic [LEN_W-1:0] commit_len;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;
  logic             drain_busy;

  lfc_parser #(.MAX_USER(MAX_USER), .LEN_W(LEN_W)) u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_char_err(in_char_err),
    .hold       (drain_busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit     (commit),
    .commit_len (commit_len),
    .reject_q   (frame_err),
    .ack_q      (ack_good)
  );

  lfc_store #(.DEPTH(MAX_USER)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  lfc_drain #(.MAX_USER(MAX_USER), .LEN_W(LEN_W)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .commit_len(commit_len),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .frame_good(frame_good),
    .busy      (drain_busy)
  );

  p_err_ack_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && ack_good));

  p_no_release_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$rose(out_valid));

  p_last_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_writes_not_during_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !wr_en);

endmodule

// File: tb/tb_link_frame_checker.sv
module tb_link_frame_checker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic       in_char_err = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_last;
  logic       out_ready = 1'b1;
  logic       frame_good;
  logic       frame_err;
  logic       ack_good;

  link_frame_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_char_err(in_char_err), .out_valid(out_valid), .out_byte(out_byte),
    .out_last(out_last), .out_ready(out_ready), .frame_good(frame_good),
    .frame_err(frame_err), .ack_good(ack_good)
  );

  always #2 clk = ~clk;

  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   stall = 1'b0;
  bit   fin = 1'b0;
  int   n_good = 0;
  int   n_err = 0;
  int   n_ack = 0;
  logic [7:0] cap_b [$];
  logic       cap_l [$];
  logic [7:0] exp_b [$];

  // ready pattern changes just after the edge so negedge sampling sees it settled
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        cap_b.push_back(out_byte);
        cap_l.push_back(out_last);
      end
      if (frame_good) n_good++;
      if (frame_err)  n_err++;
      if (ack_good)   n_ack++;
    end
  end

  task automatic summary();
    if (!fin) begin
      fin = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic e);
    in_valid = 1'b1;
    in_byte = b;
    in_char_err = e;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_char_err = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    cap_b.delete();
    cap_l.delete();
    exp_b.delete();
    n_good = 0;
    n_err = 0;
    n_ack = 0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 3) % 256);
  endfunction

  // judge the captured outcome against the expected one
  task automatic judge(input bit ok, input string req);
    int bad = 0;
    int badl = 0;
    if (ok) begin
      check(cap_b.size() == exp_b.size(), req, "beat count", cap_b.size(), exp_b.size());
      for (int i = 0; i < cap_b.size() && i < exp_b.size(); i++) begin
        if (cap_b[i] != exp_b[i]) bad++;
        if (cap_l[i] != (i == exp_b.size() - 1)) badl++;
      end
      check(bad == 0, req, "data mismatches", bad, 0);
      check(badl == 0, req, "last flag mismatches", badl, 0);
      check(n_good == 1, req, "frame_good pulses", n_good, 1);
      check(n_err == 0, req, "frame_err pulses", n_err, 0);
    end else begin
      check(cap_b.size() == 0, req, "beats on reject", cap_b.size(), 0);
      check(n_good == 0, req, "frame_good on reject", n_good, 0);
      check(n_err == 1, req, "frame_err pulses", n_err, 1);
    end
  endtask

  // kind: 0 good, 1 bad sum, 2 lengths differ, 3 zero length,
  //       4 bad reopen, 5 bad stop, 6 char fault at position pos
  task automatic send_long(input int L, input int seed, input int kind,
                           input int pos, input string req);
    logic [7:0] seq [$];
    logic [7:0] s = 8'd0;
    int cut;
    clear();
    for (int i = 0; i < L; i++) begin
      exp_b.push_back(pat(seed, i));
      s = s + pat(seed, i);
    end
    seq.push_back(8'h68);
    seq.push_back(8'(L));
    seq.push_back(kind == 2 ? 8'(L ^ 1) : 8'(L));
    seq.push_back(kind == 4 ? 8'h69 : 8'h68);
    for (int i = 0; i < L; i++) seq.push_back(exp_b[i]);
    seq.push_back(kind == 1 ? s + 8'd1 : s);
    seq.push_back(kind == 5 ? 8'h17 : 8'h16);
    cut = seq.size();
    if (kind == 2 || kind == 3) cut = 3;
    if (kind == 4) cut = 4;
    if (kind == 6) cut = pos + 1;
    for (int i = 0; i < cut; i++) put(seq[i], (kind == 6 && i == pos));
    idle(3 * L + 12);
    judge(kind == 0, req);
  endtask

  // kind: 0 good, 1 bad sum, 2 bad stop
  task automatic send_short(input logic [7:0] c, input logic [7:0] a,
                            input int kind, input string req);
    logic [7:0] s;
    clear();
    s = c + a;
    exp_b.push_back(c);
    exp_b.push_back(a);
    put(8'h10, 1'b0);
    put(c, 1'b0);
    put(a, 1'b0);
    put(kind == 1 ? ~s : s, 1'b0);
    put(kind == 2 ? 8'h61 : 8'h16, 1'b0);
    idle(12);
    judge(kind == 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 1'b0, "R12", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && frame_good == 1'b0, "R12", "outputs after reset",
          out_valid + frame_good, 0);
    check(frame_err == 1'b0 && ack_good == 1'b0, "R12", "pulses after reset",
          frame_err + ack_good, 0);

    // R1: long frames over a sweep of lengths, stalls on odd lengths (R10)
    for (int L = 1; L <= 48; L++) begin
      stall = (L % 2) == 1;
      send_long(L, L, 0, 0, (L % 2) ? "R10" : "R1");
    end
    stall = 1'b0;
    send_long(255, 9, 0, 0, "R1");

    // R2: short frames over a sweep of control/address values
    for (int i = 0; i < 256; i += 5) send_short(8'(i), 8'(255 - i), 0, "R2");

    // R3: lone acknowledge, exact timing
    clear();
    put(8'hE5, 1'b0);
    check(ack_good == 1'b1, "R3", "ack_good after E5", ack_good, 1);
    idle(4);
    check(n_ack == 1 && cap_b.size() == 0, "R3", "single ack, no beats",
          n_ack * 100 + cap_b.size(), 100);

    // R4: checksum faults
    for (int L = 1; L <= 10; L++) send_long(L, L + 40, 1, 0, "R4");
    send_short(8'h53, 8'hC1, 1, "R4");

    // R5: length faults
    send_long(5, 1, 2, 0, "R5");
    send_long(0, 1, 3, 0, "R5");

    // R6: bad reopening symbol
    send_long(6, 2, 4, 0, "R6");

    // R7: bad closing octet, exact timing
    send_short(8'h01, 8'h02, 2, "R7");
    clear();
    put(8'h10, 1'b0); put(8'h20, 1'b0); put(8'h30, 1'b0); put(8'h50, 1'b0);
    put(8'h15, 1'b0);
    check(frame_err == 1'b1, "R7", "frame_err one cycle after stop", frame_err, 1);
    idle(4);
    send_long(4, 3, 5, 0, "R7");

    // R8: character fault at every position of a 4-octet long frame (10 octets)
    for (int p = 0; p < 10; p++) send_long(4, 5, 6, p, "R8");
    // R8: fault on a correct closing octet wins
    clear();
    put(8'h10, 1'b0); put(8'h44, 1'b0); put(8'h55, 1'b0); put(8'h99, 1'b0);
    put(8'h16, 1'b1);
    check(frame_err == 1'b1 && out_valid == 1'b0, "R8", "fault on stop octet",
          frame_err * 10 + out_valid, 10);
    idle(6);
    check(n_good == 0 && cap_b.size() == 0, "R8", "nothing released",
          n_good + cap_b.size(), 0);

    // R9: all other bytes while hunting are ignored
    clear();
    for (int b = 0; b < 256; b++)
      if (b != 8'h68 && b != 8'h10 && b != 8'hE5) put(8'(b), 1'b0);
    idle(4);
    check(n_err + n_ack + n_good + cap_b.size() == 0, "R9", "pulses/beats from noise",
          n_err + n_ack + n_good + cap_b.size(), 0);
    send_long(3, 77, 0, 0, "R9");

    // R10: no beat before the stop octet is checked
    clear();
    exp_b.push_back(8'hA1);
    exp_b.push_back(8'h0B);
    put(8'h10, 1'b0); put(8'hA1, 1'b0); put(8'h0B, 1'b0); put(8'hAC, 1'b0);
    idle(3);
    check(out_valid == 1'b0, "R10", "out_valid before stop", out_valid, 0);
    put(8'h16, 1'b0);
    check(out_valid == 1'b1, "R10", "out_valid after stop", out_valid, 1);
    idle(8);
    judge(1'b1, "R10");

    // R11: bytes during the drain are discarded
    stall = 1'b1;
    clear();
    for (int i = 0; i < 6; i++) exp_b.push_back(pat(11, i));
    begin
      logic [7:0] s = 8'd0;
      put(8'h68, 1'b0); put(8'd6, 1'b0); put(8'd6, 1'b0); put(8'h68, 1'b0);
      for (int i = 0; i < 6; i++) begin
        put(exp_b[i], 1'b0);
        s = s + exp_b[i];
      end
      put(s, 1'b0);
      put(8'h16, 1'b0);
      put(8'hE5, 1'b0); put(8'hE5, 1'b0); put(8'hE5, 1'b0);
    end
    idle(30);
    stall = 1'b0;
    judge(1'b1, "R11");
    check(n_ack == 0, "R11", "ack from bytes during drain", n_ack, 0);

    summary();
  end

endmodule